// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a synchronous host and an asynchronous 4-bit-wide dynamic RAM that keeps its read data valid after the column strobe rises. A host request carries a 22-bit word address, a write flag and write data. The controller splits the address into a row half and a column half and sends them one after the other on one shared address bus. It drives the active-low row strobe, column strobe, write enable and output enable, and returns read data with a one-cycle acknowledge pulse. Every minimum pulse width and spacing is a cycle count set by a parameter. Each count is the nanosecond figure divided by the clock period and rounded up.

Once a row is open it stays open. A later request to the same row becomes a page access, which is a column strobe only. A request to another row, an idle spell, an approaching limit on how long the row strobe may stay low, or a refresh request closes the row and precharges it. Refresh and power-on sequencing belong to a neighbouring block. That block raises `ref_req`. The controller completes any access in progress, closes the row, and then holds `ref_gnt` high with both strobes inactive until the request is withdrawn.

The state machine has seven states. ST_IDLE has all strobes high. ST_REFRESH holds the grant. ST_ACTIVATE drives the row strobe low with the row address for the row-to-column delay. ST_CAS_LOW drives the column strobe low with the column address. ST_CAS_HIGH is the column precharge, in which read data is captured. ST_ROW_OPEN holds the row open and waits. ST_PRECHARGE holds the row strobe high.

The transitions are:
- idle→refresh on a refresh request; refresh→idle when it is dropped.
- idle→activate on a host request.
- activate→cas_low, cas_low→cas_high and cas_high→row_open, each when its timer expires.
- row_open→cas_low on a request that hits the open row.
- row_open→precharge on a row miss, idle timeout, row-strobe limit or refresh request, once the minimum row-strobe low time has passed.
- precharge→idle when the precharge timer expires.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row is host_addr[21:11] and is on mem_addr when mem_ras_n falls. The column is host_addr[10:0] and is on mem_addr when mem_cas_n falls. mem_addr stays stable while mem_cas_n is low.
- R2: mem_cas_n first falls no sooner than T_RCD cycles after mem_ras_n falls.
- R3: mem_ras_n stays low for at least T_RAS cycles and high for at least T_RP cycles before it falls again.
- R4: mem_cas_n stays low for at least T_CASL cycles and high for at least T_CP cycles between pulses.
- R5: In a read, mem_we_n is 1, mem_oe_n is 0 and mem_dq_oe is 0 while the column strobe is low. host_rdata is sampled at the end of the first cycle after the column strobe rises. host_ack then pulses in the next cycle. From idle, the acknowledge is seen T_RCD+T_CASL+2 cycles after the request.
- R6: In a write, mem_we_n falls together with mem_cas_n and does not change while the column strobe is low. mem_dq_oe is 1 with host_wdata on mem_dq_out, and mem_oe_n is 1.
- R7: A request to the open row is served without a new row strobe. Its acknowledge comes T_CASL+2 cycles after the request.
- R8: A request to another row precharges and reopens. Its acknowledge comes T_RP+T_RCD+T_CASL+3 cycles after the request.
- R9: An open row with no request for T_IDLE cycles is closed.
- R10: A single low pulse of mem_ras_n never exceeds T_RASMAX cycles. Page accesses that would break the limit reopen the row first.
- R11: While ref_req is high, the controller finishes an access already started and accepts no new one. It then raises ref_gnt with mem_ras_n and mem_cas_n high. A request held during the grant is served after ref_req falls.
- R12: host_ack is high for exactly one cycle per request.
- R13: mem_cas_n is never low while mem_ras_n is high, so the controller never issues a refresh-type cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request; hold with its fields until host_ack |
| host_addr | input | 22 | Word address, row in the upper half |
| host_we | input | 1 | 1 for write, 0 for read |
| host_wdata | input | 4 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Read data, valid with host_ack |
| ref_req | input | 1 | Refresh block asks for the bus |
| ref_gnt | output | 1 | Bus handed to the refresh block |
| mem_addr | output | 11 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Data to the device |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 4 | Data from the device |

## Verification
The bound checker watches the strobe timing on every cycle: the row-to-column spacing, the minimum pulse widths on both strobes, the ceiling on row-strobe low time, write enable and address stability under a low column strobe, data drive direction, the single-cycle acknowledge, and strobes idle under a grant. It cannot show that the right row and column arrive at the device, that read data returns the value last written, or the latency of hits, misses and reopen paths. It also cannot show whether idle timeout and refresh hand-off choose the right transition. The bench shows these by running request sequences against a device model and computing latencies and data arithmetically.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_REFRESH   = 3'd1,
        ST_ACTIVATE  = 3'd2,
        ST_CAS_LOW   = 3'd3,
        ST_CAS_HIGH  = 3'd4,
        ST_ROW_OPEN  = 3'd5,
        ST_PRECHARGE = 3'd6
    } ctl_state_e;

endpackage

// File: rtl/edo_wait_cnt.sv
// Down-counter timing one state's dwell; done when it reaches zero.
module edo_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_row_tracker.sv
// Remembers the open row and watches row-strobe age and idle time.
module edo_row_tracker #(
    parameter int ROW_W    = 11,
    parameter int T_RAS    = 6,
    parameter int T_RASMAX = 10000,
    parameter int T_CASL   = 2,
    parameter int T_CP     = 1,
    parameter int T_IDLE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_load,
    input  logic [ROW_W-1:0] row_in,
    input  logic             row_active,
    input  logic             idle_tick,
    output logic             row_hit,
    output logic             ras_ok,
    output logic             ras_max_hit,
    output logic             idle_expired
);
    localparam int CNT_W = $clog2(T_RASMAX + 1) + 1;
    localparam int IDL_W = $clog2(T_IDLE + 1) + 1;
    // A page access from row_open adds T_CASL+T_CP cycles plus one more
    // row_open cycle before a close can follow.
    localparam logic [CNT_W-1:0] MAX_LIM = CNT_W'(T_RASMAX - T_CASL - T_CP - 1);
    localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(T_RAS - 1);
    localparam logic [IDL_W-1:0] IDL_LIM = IDL_W'(T_IDLE - 1);

    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] ras_cnt_q;
    logic [IDL_W-1:0] idle_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q      <= '0;
            ras_cnt_q  <= '0;
            idle_cnt_q <= '0;
        end else begin
            if (row_load) row_q <= row_in;
            if (!row_active)              ras_cnt_q <= '0;
            else if (ras_cnt_q != '1)     ras_cnt_q <= ras_cnt_q + 1'b1;
            if (!idle_tick)               idle_cnt_q <= '0;
            else if (idle_cnt_q != '1)    idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    assign row_hit      = (row_q == row_in);
    assign ras_ok       = (ras_cnt_q >= MIN_LIM);
    assign ras_max_hit  = (ras_cnt_q >= MAX_LIM);
    assign idle_expired = idle_tick && (idle_cnt_q >= IDL_LIM);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_dram_pkg::*;
#(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 11,
    parameter int DQ_W     = 4,
    parameter int T_RCD    = 3,
    parameter int T_CASL   = 2,
    parameter int T_CP     = 1,
    parameter int T_RP     = 4,
    parameter int T_RAS    = 6,
    parameter int T_RASMAX = 10000,
    parameter int T_IDLE   = 16,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int A_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [DQ_W-1:0]   host_wdata,
    output logic              host_ack,
    output logic [DQ_W-1:0]   host_rdata,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic [A_W-1:0]    mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DQ_W-1:0]   mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DQ_W-1:0]   mem_dq_in
);
    localparam int T_M1 = (T_RCD > T_CASL) ? T_RCD : T_CASL;
    localparam int T_M2 = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int T_MX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int TW   = $clog2(T_MX + 1) + 1;

    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              we_q, we_d;
    logic [DQ_W-1:0]   wd_q, wd_d;
    logic              cap_q;
    logic              accept, row_load, row_active, idle_tick;
    logic              tmr_done, row_hit, ras_ok, ras_max_hit, idle_expired;
    logic              close_want;
    logic [TW-1:0]     tmr_val;

    edo_wait_cnt #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_d != state_q),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    edo_row_tracker #(
        .ROW_W(ROW_W), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX),
        .T_CASL(T_CASL), .T_CP(T_CP), .T_IDLE(T_IDLE)
    ) u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_load     (row_load),
        .row_in       (host_addr[ADDR_W-1:COL_W]),
        .row_active   (row_active),
        .idle_tick    (idle_tick),
        .row_hit      (row_hit),
        .ras_ok       (ras_ok),
        .ras_max_hit  (ras_max_hit),
        .idle_expired (idle_expired)
    );

    assign row_active = (state_q == ST_ACTIVATE) || (state_q == ST_CAS_LOW) ||
                        (state_q == ST_CAS_HIGH) || (state_q == ST_ROW_OPEN);
    assign idle_tick  = (state_q == ST_ROW_OPEN) && !host_req;
    assign close_want = ref_req || idle_expired || ras_max_hit || (host_req && !row_hit);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req)       state_d = ST_REFRESH;
                else if (host_req) state_d = ST_ACTIVATE;
            end
            ST_REFRESH:   if (!ref_req) state_d = ST_IDLE;
            ST_ACTIVATE:  if (tmr_done) state_d = ST_CAS_LOW;
            ST_CAS_LOW:   if (tmr_done) state_d = ST_CAS_HIGH;
            ST_CAS_HIGH:  if (tmr_done) state_d = ST_ROW_OPEN;
            ST_ROW_OPEN: begin
                if (close_want) begin
                    if (ras_ok) state_d = ST_PRECHARGE;
                end else if (host_req) begin
                    state_d = ST_CAS_LOW;
                end
            end
            ST_PRECHARGE: if (tmr_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign row_load = (state_q == ST_IDLE) && (state_d == ST_ACTIVATE);
    assign accept   = row_load || ((state_q == ST_ROW_OPEN) && (state_d == ST_CAS_LOW));
    assign addr_d   = accept ? host_addr  : addr_q;
    assign we_d     = accept ? host_we    : we_q;
    assign wd_d     = accept ? host_wdata : wd_q;

    always_comb begin
        unique case (state_d)
            ST_ACTIVATE:  tmr_val = TW'(T_RCD - 1);
            ST_CAS_LOW:   tmr_val = TW'(T_CASL - 1);
            ST_CAS_HIGH:  tmr_val = TW'(T_CP - 1);
            ST_PRECHARGE: tmr_val = TW'(T_RP - 1);
            default:      tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            we_q    <= we_d;
            wd_q    <= wd_d;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= 1'b0;
            host_ack   <= 1'b0;
            host_rdata <= '0;
            ref_gnt    <= 1'b0;
            mem_addr   <= '0;
            mem_ras_n  <= 1'b1;
            mem_cas_n  <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_dq_out <= '0;
            mem_dq_oe  <= 1'b0;
        end else begin
            cap_q    <= (state_q == ST_CAS_LOW) && (state_d == ST_CAS_HIGH);
            host_ack <= cap_q;
            if (cap_q && !we_q) host_rdata <= mem_dq_in;
            ref_gnt   <= 1'b0;
            mem_ras_n <= 1'b1;
            mem_cas_n <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            unique case (state_d)
                ST_IDLE, ST_PRECHARGE: begin end
                ST_REFRESH:  ref_gnt <= 1'b1;
                ST_ACTIVATE: begin
                    mem_ras_n <= 1'b0;
                    mem_addr  <= A_W'(addr_d[ADDR_W-1:COL_W]);
                end
                ST_CAS_LOW: begin
                    mem_ras_n  <= 1'b0;
                    mem_cas_n  <= 1'b0;
                    mem_addr   <= A_W'(addr_d[COL_W-1:0]);
                    mem_we_n   <= !we_d;
                    mem_oe_n   <= we_d;
                    mem_dq_oe  <= we_d;
                    mem_dq_out <= wd_d;
                end
                ST_CAS_HIGH: begin
                    mem_ras_n <= 1'b0;
                    mem_oe_n  <= we_d;
                end
                ST_ROW_OPEN: mem_ras_n <= 1'b0;
                default: begin end
            endcase
        end
    end
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk #(
    parameter int A_W      = 11,
    parameter int T_RCD    = 3,
    parameter int T_CASL   = 2,
    parameter int T_CP     = 1,
    parameter int T_RP     = 4,
    parameter int T_RAS    = 6,
    parameter int T_RASMAX = 10000
) (
    input logic           clk,
    input logic           rst_n,
    input logic [A_W-1:0] mem_addr,
    input logic           mem_ras_n,
    input logic           mem_cas_n,
    input logic           mem_we_n,
    input logic           mem_oe_n,
    input logic           mem_dq_oe,
    input logic           host_ack,
    input logic           ref_gnt
);
    localparam int CW = $clog2(T_RASMAX + 2) + 1;

    logic [CW-1:0] ras_lo_run, ras_hi_run, cas_lo_run, cas_hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_run <= '0;
            ras_hi_run <= CW'(T_RP);
            cas_lo_run <= '0;
            cas_hi_run <= CW'(T_CP);
        end else begin
            ras_lo_run <= mem_ras_n  ? '0 : ((ras_lo_run == '1) ? ras_lo_run : ras_lo_run + 1'b1);
            ras_hi_run <= !mem_ras_n ? '0 : ((ras_hi_run == '1) ? ras_hi_run : ras_hi_run + 1'b1);
            cas_lo_run <= mem_cas_n  ? '0 : ((cas_lo_run == '1) ? cas_lo_run : cas_lo_run + 1'b1);
            cas_hi_run <= !mem_cas_n ? '0 : ((cas_hi_run == '1) ? cas_hi_run : cas_hi_run + 1'b1);
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);                                        // R13
    AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (ras_lo_run >= CW'(T_RCD)));                  // R2
    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n) |-> (ras_lo_run >= CW'(T_RAS)));                  // R3
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (ras_hi_run >= CW'(T_RP)));                   // R3
    AST_CAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cas_n) |-> (cas_lo_run >= CW'(T_CASL)));                 // R4
    AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (cas_hi_run >= CW'(T_CP)));                   // R4
    AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_addr));          // R1
    AST_WE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && $past(!mem_cas_n)) |-> $stable(mem_we_n));          // R6
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && !mem_we_n) |-> (mem_dq_oe && mem_oe_n));            // R6
    AST_READ_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cas_n && mem_we_n) |-> (!mem_oe_n && !mem_dq_oe));           // R5
    AST_RAS_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        ras_lo_run <= CW'(T_RASMAX));                                      // R10
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);                                           // R12
    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (mem_ras_n && mem_cas_n && !host_ack));                // R11
endmodule

bind edo_dram_ctrl edo_dram_chk #(
    .A_W(A_W), .T_RCD(T_RCD), .T_CASL(T_CASL), .T_CP(T_CP),
    .T_RP(T_RP), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .host_ack  (host_ack),
    .ref_gnt   (ref_gnt)
);

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
    localparam int T_RCD = 3, T_CASL = 2, T_CP = 1, T_RP = 4, T_RAS = 6;
    localparam int T_RASMAX = 40, T_IDLE = 6;
    localparam int LAT_IDLE = T_RCD + T_CASL + 2;
    localparam int LAT_HIT  = T_CASL + 2;
    localparam int LAT_MISS = T_RP + T_RCD + T_CASL + 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_we = 1'b0, ref_req = 1'b0;
    logic [21:0] host_addr = '0;
    logic [3:0]  host_wdata = '0, mem_dq_in = '0, host_rdata, mem_dq_out;
    logic host_ack, ref_gnt, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [10:0] mem_addr;

    int checks = 0, errors = 0;
    int ras_falls = 0, cbr_err = 0, wr_err = 0, rd_err = 0, ack_err = 0;
    int ras_run = 0, ras_run_max = 0;
    logic [10:0] m_row = '0, m_col = '0;
    logic pr_ras = 1'b1, pr_cas = 1'b1, pr_ack = 1'b0;
    bit [3:0] mem [int];
    bit open_v = 0;
    logic [10:0] open_row = '0;

    always #10 clk = ~clk;

    edo_dram_ctrl #(
        .T_RCD(T_RCD), .T_CASL(T_CASL), .T_CP(T_CP), .T_RP(T_RP),
        .T_RAS(T_RAS), .T_RASMAX(T_RASMAX), .T_IDLE(T_IDLE)
    ) u_edo_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Device model: latches on strobe falls, holds read data after CAS rises.
    always @(negedge clk) begin
        if (pr_ras && !mem_ras_n) begin
            ras_falls++;
            m_row = mem_addr;
            if (!mem_cas_n) cbr_err++;
        end
        if (!mem_cas_n && mem_ras_n) cbr_err++;
        if (pr_cas && !mem_cas_n) begin
            m_col = mem_addr;
            if (!mem_we_n) begin
                mem[int'({m_row, m_col})] = mem_dq_out;
                if (!mem_dq_oe || !mem_oe_n) wr_err++;
            end else begin
                mem_dq_in = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 4'h0;
                if (mem_oe_n || mem_dq_oe) rd_err++;
            end
        end
        if (mem_ras_n && mem_cas_n) mem_dq_in = 4'h0;
        ras_run = mem_ras_n ? 0 : ras_run + 1;
        if (ras_run > ras_run_max) ras_run_max = ras_run;
        if (host_ack && pr_ack) ack_err++;
        pr_ras = mem_ras_n; pr_cas = mem_cas_n; pr_ack = host_ack;
    end

    function automatic logic [10:0] row_of(int r); return 11'((r * 677 + 3) & 2047); endfunction
    function automatic logic [10:0] col_of(int c); return 11'((c * 337 + 5) & 2047); endfunction
    function automatic logic [21:0] mk(int r, int c); return {row_of(r), col_of(c)}; endfunction
    function automatic logic [3:0] wdat(logic [21:0] a); return a[3:0] ^ a[14:11] ^ a[21:18] ^ 4'h5; endfunction
    function automatic int lat_for(logic [21:0] a);
        if (!open_v) return LAT_IDLE;
        return (a[21:11] == open_row) ? LAT_HIT : LAT_MISS;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!host_ack && n < 200);
    endtask

    task automatic access(bit we, logic [21:0] a, int exp_lat, string tag);
        int n;
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wdat(a);
        wait_ack(n);
        host_req = 1'b0;
        chk(host_ack, "R12 ack seen", int'(host_ack), 1);
        if (exp_lat >= 0) chk(n == exp_lat, tag, n, exp_lat);
        chk(m_row == a[21:11] && m_col == a[10:0], "R1 row/col split",
            int'({m_row, m_col}), int'(a));
        if (!we) chk(host_rdata == wdat(a), "R5 read data", int'(host_rdata), int'(wdat(a)));
        open_v = 1'b1; open_row = a[21:11];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0, n, noack, ras_hi;
        repeat (4) @(negedge clk);
        chk(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R13 reset strobes high",
            int'({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}), 15);
        chk(!host_ack && !ref_gnt && !mem_dq_oe, "R11 reset grant/ack low",
            int'({host_ack, ref_gnt, mem_dq_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Write sweep: 4 rows x 4 columns, one row strobe per row (R6, R7, R8)
        for (int r = 0; r < 4; r++) begin
            f0 = ras_falls;
            for (int c = 0; c < 4; c++)
                access(1'b1, mk(r, c), lat_for(mk(r, c)), "R8/R7 write latency");
            chk(ras_falls - f0 == 1, "R7 one row strobe per row", ras_falls - f0, 1);
        end
        // Read-back sweep, columns in reverse order (R5, R7, R8)
        for (int r = 0; r < 4; r++) begin
            f0 = ras_falls;
            for (int c = 3; c >= 0; c--)
                access(1'b0, mk(r, c), lat_for(mk(r, c)), "R8/R7 read latency");
            chk(ras_falls - f0 == 1, "R7 page reads share a row", ras_falls - f0, 1);
        end

        // Idle timeout (R9)
        for (int k = 1; k <= T_IDLE; k++) begin
            @(negedge clk);
            if (k == T_IDLE - 1) chk(!mem_ras_n, "R9 row still open", int'(mem_ras_n), 0);
            if (k == T_IDLE)     chk(mem_ras_n, "R9 row closed on timeout", int'(mem_ras_n), 1);
        end
        open_v = 1'b0;
        repeat (T_RP + 2) @(negedge clk);

        // Long page run: row-strobe ceiling forces one reopen at access 9 (R10)
        f0 = ras_falls;
        for (int i = 0; i < 12; i++)
            access(1'b0, mk(0, i % 4), (i == 0) ? LAT_IDLE : ((i == 9) ? LAT_MISS : LAT_HIT),
                   "R10 long-run latency");
        chk(ras_falls - f0 == 2, "R10 reopen count", ras_falls - f0, 2);
        repeat (T_IDLE + T_RP + 3) @(negedge clk);
        open_v = 1'b0;

        // Refresh raised during an access from idle (R11)
        host_req = 1'b1; host_we = 1'b0; host_addr = mk(1, 0);
        @(negedge clk); n = 1;
        ref_req = 1'b1;
        while (!host_ack && n < 200) begin @(negedge clk); n++; end
        host_req = 1'b0;
        chk(n == LAT_IDLE, "R11 in-flight access finishes", n, LAT_IDLE);
        chk(host_rdata == wdat(mk(1, 0)), "R11 in-flight data", int'(host_rdata), int'(wdat(mk(1, 0))));
        n = 0;
        while (!ref_gnt && n < 50) begin @(negedge clk); n++; end
        chk(ref_gnt && mem_ras_n && mem_cas_n, "R11 grant with strobes idle",
            int'({ref_gnt, mem_ras_n, mem_cas_n}), 7);
        host_req = 1'b1; host_addr = mk(1, 1);
        noack = 0; ras_hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (host_ack) noack++;
            if (mem_ras_n && ref_gnt) ras_hi++;
        end
        chk(noack == 0 && ras_hi == 10, "R11 request held off during grant", ras_hi - 10 * noack, 10);
        ref_req = 1'b0;
        wait_ack(n);
        host_req = 1'b0;
        chk(n == LAT_IDLE + 1, "R11 held request served after release", n, LAT_IDLE + 1);
        chk(host_rdata == wdat(mk(1, 1)), "R11 held request data", int'(host_rdata), int'(wdat(mk(1, 1))));

        // Refresh raised with a page hit pending on an open row (R11)
        ref_req = 1'b1; host_req = 1'b1; host_addr = mk(1, 2);
        noack = 0; n = 0;
        while (!ref_gnt && n < 50) begin @(negedge clk); n++; if (host_ack) noack++; end
        chk(ref_gnt && noack == 0, "R11 refresh wins over page hit", noack, 0);
        ref_req = 1'b0;
        wait_ack(n);
        host_req = 1'b0;
        chk(n == LAT_IDLE + 1, "R11 hit served after refresh", n, LAT_IDLE + 1);
        chk(host_rdata == wdat(mk(1, 2)), "R5 data after refresh", int'(host_rdata), int'(wdat(mk(1, 2))));

        repeat (4) @(negedge clk);
        chk(cbr_err == 0, "R13 column strobe only under row strobe", cbr_err, 0);
        chk(wr_err == 0, "R6 write drive at column strobe", wr_err, 0);
        chk(rd_err == 0, "R5 read enables at column strobe", rd_err, 0);
        chk(ack_err == 0, "R12 single-cycle ack", ack_err, 0);
        chk(ras_run_max <= T_RASMAX, "R10 row strobe ceiling", ras_run_max, T_RASMAX);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule